// File: doc/BRIEF.md
# Lockable Debug Policy Register File

This block keeps the debug authorization policy of a chip in a small set of memory-mapped registers and drives it onto a policy bus seen by every debug consumer. The bus carries a 7-bit category, a 4-bit valid flag and a 4-bit relocked flag. The two flags use a redundant 4-bit encoding: 0x6 means true and 0x9 means false. Software changes a policy register by writing the same value twice in a row to that register. After the valid flag becomes true, the policy is frozen until reset.

A select input chooses the source of the policy. One source is a set of hardware policy inputs. The other is the software registers. The same choice feeds the output bus and two read-only trace words, so software can always read back the policy that consumers see. An alert-test word fires one-cycle pulses on a fatal alert output and a recoverable alert output. The recoverable alert also pulses when a confirmation write does not match or when a flag write uses an encoding that is not allowed. A status word holds a few authorization progress bits that software writes.

Requests arrive on a valid/ready port with 3-bit word addresses. Byte offset = word × 4. `req_ready_o` is tied high, so the block never applies back-pressure and accepts a request in every cycle where `req_valid_i` is high. A read produces `rsp_valid_o` with data in the next cycle. The response channel has no ready signal, so the requester must take the response in that cycle. A write produces no response.

Top module: `dbg_policy_regs`

## Requirements
- R1: After reset the software category is 0x50 and the software valid and relocked flags are 0x9. The status word is 0. With select low, the category trace (word 4) reads 0x50 and the flag trace (word 5) reads 0x99.
- R2: The first write to word 1, 2 or 3 only arms that register and changes no state. The next write to the same register commits the value if its field bits equal the armed value. Either way, that second write disarms the register.
- R3: If the second write carries different field bits, the update is dropped. `alert_recov_o` pulses for exactly the cycle after that write.
- R4: The valid field (word 1, bits 3:0) can only be set. A committed 0x6 makes it true. A committed 0x9 leaves it as it was. Any other committed value leaves it unchanged and pulses `alert_recov_o`. It never holds a value other than 0x6 or 0x9.
- R5: The relocked field (word 3, bits 3:0) takes a committed 0x6 or 0x9. Any other committed value is dropped and pulses `alert_recov_o`. The category field (word 2, bits 6:0) takes any committed value.
- R6: While valid is 0x6, writes to words 1, 2 and 3 are ignored. They do not arm a register, change a field or raise an alert.
- R7: A write to word 0 pulses `alert_fatal_o` when bit 0 is 1 and `alert_recov_o` when bit 1 is 1, for the single cycle after the write. A read of word 0 returns 0.
- R8: With `hw_policy_sel_i` high, the policy bus and the trace words show the hardware inputs. With it low, they show the software fields. Word 5 holds valid in bits 3:0 and relocked in bits 7:4.
- R9: The status word (word 6) is a plain read/write register and is not frozen by the lock. It keeps bits 0, 4, 5, 6 and 7 of a write. All other bits read 0.
- R10: `req_ready_o` is always 1. A read returns `rsp_valid_o` high with its data in the next cycle. A write returns no response. Word 7 and all bits above a field read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Word address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data present |
| rsp_rdata_o | output | 32 | Read data |
| hw_policy_sel_i | input | 1 | 1 = hardware policy in effect |
| hw_category_i | input | 7 | Hardware category |
| hw_valid_i | input | 4 | Hardware valid flag |
| hw_relocked_i | input | 4 | Hardware relocked flag |
| pol_category_o | output | 7 | Policy bus category |
| pol_valid_o | output | 4 | Policy bus valid flag |
| pol_relocked_o | output | 4 | Policy bus relocked flag |
| alert_fatal_o | output | 1 | Fatal alert pulse |
| alert_recov_o | output | 1 | Recoverable alert pulse |

## Verification
A confirming software write and a change of the source select can land in the same cycle. The bench raises `hw_policy_sel_i` in the same cycle as the second, matching category write. It expects the bus to show the hardware category at once. When the select drops again, it expects the newly committed software value. A behavioural model with per-register arm flags is stepped on every clock edge and compared against all outputs in every cycle. This catches a commit that is lost or applied to the wrong source, and a trace word that lags the bus.

// File: rtl/dbg_pol_pkg.sv
package dbg_pol_pkg;
  localparam int ADDR_W = 3;
  localparam logic [3:0] MUBI_TRUE  = 4'h6;
  localparam logic [3:0] MUBI_FALSE = 4'h9;

  typedef enum logic [ADDR_W-1:0] {
    W_ALERT  = 3'd0,
    W_VALID  = 3'd1,
    W_CAT    = 3'd2,
    W_RELOCK = 3'd3,
    W_TR_CAT = 3'd4,
    W_TR_VR  = 3'd5,
    W_STAT   = 3'd6,
    W_NONE   = 3'd7
  } word_e;
endpackage

// File: rtl/dbg_pol_shadow.sv
module dbg_pol_shadow #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         commit_o,
  output logic         mismatch_o
);
  logic         armed_q;
  logic [W-1:0] stage_q;

  always_comb begin
    commit_o   = wr_i && armed_q && (wdata_i == stage_q);
    mismatch_o = wr_i && armed_q && (wdata_i != stage_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      stage_q <= '0;
    end else if (wr_i) begin
      if (armed_q) begin
        armed_q <= 1'b0;
      end else begin
        armed_q <= 1'b1;
        stage_q <= wdata_i;
      end
    end
  end

  // R2: a confirming write always leaves the register disarmed
  p_second_write_disarms_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && wr_i) |=> !armed_q);
  // R2: the first write arms and stores the value
  p_first_write_arms_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && wr_i) |=> (armed_q && stage_q == $past(wdata_i)));
endmodule

// File: rtl/dbg_pol_rdmux.sv
module dbg_pol_rdmux #(
  parameter int DATA_W = 32,
  parameter int CAT_W  = 7,
  parameter int MUBI_W = 4,
  parameter int STAT_W = 8
) (
  input  dbg_pol_pkg::word_e word_i,
  input  logic [MUBI_W-1:0]  sw_valid_i,
  input  logic [CAT_W-1:0]   sw_cat_i,
  input  logic [MUBI_W-1:0]  sw_relock_i,
  input  logic [CAT_W-1:0]   eff_cat_i,
  input  logic [MUBI_W-1:0]  eff_valid_i,
  input  logic [MUBI_W-1:0]  eff_relock_i,
  input  logic [STAT_W-1:0]  status_i,
  output logic [DATA_W-1:0]  rdata_o
);
  import dbg_pol_pkg::*;

  always_comb begin
    rdata_o = '0;
    unique case (word_i)
      W_VALID:  rdata_o = DATA_W'(sw_valid_i);
      W_CAT:    rdata_o = DATA_W'(sw_cat_i);
      W_RELOCK: rdata_o = DATA_W'(sw_relock_i);
      W_TR_CAT: rdata_o = DATA_W'(eff_cat_i);
      W_TR_VR:  rdata_o = DATA_W'({eff_relock_i, eff_valid_i});
      W_STAT:   rdata_o = DATA_W'(status_i);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dbg_policy_regs.sv
module dbg_policy_regs #(
  parameter int          DATA_W    = 32,
  parameter int          CAT_W     = 7,
  parameter int          MUBI_W    = 4,
  parameter int          STAT_W    = 8,
  parameter logic [6:0]  CAT_RST   = 7'h50,
  parameter logic [7:0]  STAT_MASK = 8'hF1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic                           req_write_i,
  input  logic [dbg_pol_pkg::ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]              req_wdata_i,
  output logic                           rsp_valid_o,
  output logic [DATA_W-1:0]              rsp_rdata_o,
  input  logic                           hw_policy_sel_i,
  input  logic [CAT_W-1:0]               hw_category_i,
  input  logic [MUBI_W-1:0]              hw_valid_i,
  input  logic [MUBI_W-1:0]              hw_relocked_i,
  output logic [CAT_W-1:0]               pol_category_o,
  output logic [MUBI_W-1:0]              pol_valid_o,
  output logic [MUBI_W-1:0]              pol_relocked_o,
  output logic                           alert_fatal_o,
  output logic                           alert_recov_o
);
  import dbg_pol_pkg::*;

  localparam int USED_W = (STAT_W > CAT_W) ? STAT_W : CAT_W;

  word_e               addr_w;
  logic                wr, rd, locked;
  logic [MUBI_W-1:0]   wd_mubi;
  logic [CAT_W-1:0]    wd_cat;
  logic                wr_valid, wr_cat, wr_relock;
  logic                c_valid, c_cat, c_relock;
  logic                m_valid, m_cat, m_relock;
  logic                valid_bad, relock_bad;
  logic [MUBI_W-1:0]   valid_q, relock_q;
  logic [CAT_W-1:0]    cat_q;
  logic [STAT_W-1:0]   status_q;
  logic                fatal_q, recov_q, rsp_valid_q;
  logic [DATA_W-1:0]   rsp_rdata_q, rd_data;
  logic                unused_wdata;

  assign unused_wdata = ^req_wdata_i[DATA_W-1:USED_W];

  assign addr_w    = word_e'(req_addr_i);
  assign wr        = req_valid_i && req_write_i;
  assign rd        = req_valid_i && !req_write_i;
  assign locked    = (valid_q == MUBI_TRUE);
  assign wd_mubi   = req_wdata_i[MUBI_W-1:0];
  assign wd_cat    = req_wdata_i[CAT_W-1:0];
  assign wr_valid  = wr && (addr_w == W_VALID)  && !locked;
  assign wr_cat    = wr && (addr_w == W_CAT)    && !locked;
  assign wr_relock = wr && (addr_w == W_RELOCK) && !locked;

  dbg_pol_shadow #(.W(MUBI_W)) u_sh_valid (
    .clk_i, .rst_ni, .wr_i(wr_valid), .wdata_i(wd_mubi),
    .commit_o(c_valid), .mismatch_o(m_valid));
  dbg_pol_shadow #(.W(CAT_W)) u_sh_cat (
    .clk_i, .rst_ni, .wr_i(wr_cat), .wdata_i(wd_cat),
    .commit_o(c_cat), .mismatch_o(m_cat));
  dbg_pol_shadow #(.W(MUBI_W)) u_sh_relock (
    .clk_i, .rst_ni, .wr_i(wr_relock), .wdata_i(wd_mubi),
    .commit_o(c_relock), .mismatch_o(m_relock));

  assign valid_bad  = c_valid  && (wd_mubi != MUBI_TRUE) && (wd_mubi != MUBI_FALSE);
  assign relock_bad = c_relock && (wd_mubi != MUBI_TRUE) && (wd_mubi != MUBI_FALSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= MUBI_FALSE;
      relock_q    <= MUBI_FALSE;
      cat_q       <= CAT_RST;
      status_q    <= '0;
      fatal_q     <= 1'b0;
      recov_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      if (c_valid && wd_mubi == MUBI_TRUE) valid_q <= MUBI_TRUE;
      if (c_relock && !relock_bad)         relock_q <= wd_mubi;
      if (c_cat)                           cat_q <= wd_cat;
      if (wr && addr_w == W_STAT)
        status_q <= req_wdata_i[STAT_W-1:0] & STAT_MASK[STAT_W-1:0];
      fatal_q <= wr && (addr_w == W_ALERT) && req_wdata_i[0];
      recov_q <= (wr && (addr_w == W_ALERT) && req_wdata_i[1]) ||
                 m_valid || m_cat || m_relock || valid_bad || relock_bad;
      rsp_valid_q <= rd;
      if (rd) rsp_rdata_q <= rd_data;
    end
  end

  assign pol_category_o = hw_policy_sel_i ? hw_category_i : cat_q;
  assign pol_valid_o    = hw_policy_sel_i ? hw_valid_i    : valid_q;
  assign pol_relocked_o = hw_policy_sel_i ? hw_relocked_i : relock_q;

  dbg_pol_rdmux #(.DATA_W(DATA_W), .CAT_W(CAT_W), .MUBI_W(MUBI_W), .STAT_W(STAT_W)) u_rdmux (
    .word_i(addr_w), .sw_valid_i(valid_q), .sw_cat_i(cat_q), .sw_relock_i(relock_q),
    .eff_cat_i(pol_category_o), .eff_valid_i(pol_valid_o), .eff_relock_i(pol_relocked_o),
    .status_i(status_q), .rdata_o(rd_data));

  assign req_ready_o   = 1'b1;
  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_rdata_o   = rsp_rdata_q;
  assign alert_fatal_o = fatal_q;
  assign alert_recov_o = recov_q;

  // R4: the valid field only ever holds one of the two legal encodings
  p_valid_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q == MUBI_TRUE) || (valid_q == MUBI_FALSE));
  // R4: once true, valid stays true
  p_valid_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q == MUBI_TRUE) |=> (valid_q == MUBI_TRUE));
  // R6: a locked policy keeps category and relocked
  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> ($stable(cat_q) && $stable(relock_q)));
  // R2: the category changes only right after a write to its word
  p_cat_needs_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cat_q) |-> $past(wr && addr_w == W_CAT));
  // R7: reading the alert-test word returns zero
  p_alert_word_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_q && $past(addr_w == W_ALERT)) |-> (rsp_rdata_q == '0));
  // R10: a response follows only a read request
  p_rsp_after_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_q |-> $past(rd));
endmodule

// File: tb/dbg_policy_regs_tb.sv
`timescale 1ns/1ps
module dbg_policy_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        hw_sel = 1'b0;
  logic [6:0]  hw_cat = 7'h11;
  logic [3:0]  hw_val = 4'h6, hw_rel = 4'h6;
  logic [6:0]  pol_cat;
  logic [3:0]  pol_val, pol_rel;
  logic        a_fat, a_rec;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur = "R1";

  // reference model state
  int m_cat = 'h50, m_val = 9, m_rel = 9, m_stat = 0;
  bit arm [1:3] = '{0, 0, 0};
  int stg [1:3] = '{0, 0, 0};
  bit e_fat = 0, e_rec = 0, e_rv = 0;
  int e_rd = 0;

  always #10 clk = ~clk;

  dbg_policy_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .hw_policy_sel_i(hw_sel), .hw_category_i(hw_cat), .hw_valid_i(hw_val),
    .hw_relocked_i(hw_rel),
    .pol_category_o(pol_cat), .pol_valid_o(pol_val), .pol_relocked_o(pol_rel),
    .alert_fatal_o(a_fat), .alert_recov_o(a_rec));

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur, what, act, exp);
    end
  endtask

  function automatic int m_read(int a);
    case (a)
      1: return m_val;
      2: return m_cat;
      3: return m_rel;
      4: return hw_sel ? int'(hw_cat) : m_cat;
      5: return hw_sel ? int'({hw_rel, hw_val}) : ((m_rel << 4) | m_val);
      6: return m_stat;
      default: return 0;
    endcase
  endfunction

  task automatic m_apply(int a, int f);
    if (a == 1) begin
      if (f == 6) m_val = 6;
      else if (f != 9) e_rec = 1;
    end else if (a == 2) m_cat = f;
    else begin
      if (f == 6 || f == 9) m_rel = f;
      else e_rec = 1;
    end
  endtask

  task automatic m_step();
    int f;
    e_fat = 0; e_rec = 0; e_rv = 0;
    if (req_valid && !req_write) begin
      e_rv = 1;
      e_rd = m_read(int'(req_addr));
    end
    if (req_valid && req_write) begin
      case (int'(req_addr))
        0: begin e_fat = req_wdata[0]; e_rec = req_wdata[1]; end
        1, 2, 3: if (m_val != 6) begin
          f = (req_addr == 2) ? int'(req_wdata[6:0]) : int'(req_wdata[3:0]);
          if (!arm[req_addr]) begin
            arm[req_addr] = 1; stg[req_addr] = f;
          end else begin
            arm[req_addr] = 0;
            if (f != stg[req_addr]) e_rec = 1;
            else m_apply(int'(req_addr), f);
          end
        end
        6: m_stat = int'(req_wdata) & 'hF1;
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    chk("req_ready", req_ready, 1);
    chk("pol_category", pol_cat, hw_sel ? int'(hw_cat) : m_cat);
    chk("pol_valid", pol_val, hw_sel ? int'(hw_val) : m_val);
    chk("pol_relocked", pol_rel, hw_sel ? int'(hw_rel) : m_rel);
    chk("alert_fatal", a_fat, e_fat);
    chk("alert_recov", a_rec, e_rec);
    chk("rsp_valid", rsp_valid, e_rv);
    if (e_rv) chk("rsp_rdata", int'(rsp_rdata), e_rd);
  endtask

  task automatic cyc(bit v, bit w, int a, int d);
    req_valid = v; req_write = w; req_addr = 3'(a); req_wdata = d;
    @(posedge clk);
    m_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(int a, int d); cyc(1, 1, a, d); endtask
  task automatic rd(int a); cyc(1, 0, a, 0); cyc(0, 0, 0, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state, checked during and after reset
    cur = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    idle();
    for (int a = 1; a <= 6; a++) rd(a);

    // R2: single write arms only, the matching second write commits
    cur = "R2";
    wr(2, 'h12); rd(2);
    wr(2, 'hFFFF_FF12); rd(2); rd(4);

    // R3: a mismatching confirmation drops the update and alerts
    cur = "R3";
    wr(2, 'h33); wr(2, 'h34); idle(); rd(2);
    wr(2, 'h21); wr(2, 'h21); rd(2);

    // R5: relocked encodings
    cur = "R5";
    wr(3, 6); wr(3, 6); rd(3);
    wr(3, 5); wr(3, 5); idle(); rd(3);
    wr(3, 9); wr(3, 9); rd(5);

    // R8: select in the same cycle as a confirming category write
    cur = "R8";
    wr(2, 'h0A);
    hw_sel = 1'b1; hw_cat = 7'h3C; hw_val = 4'h6; hw_rel = 4'h9;
    wr(2, 'h0A); rd(4); rd(5);
    hw_cat = 7'h01; hw_val = 4'h9; hw_rel = 4'h6; idle(); rd(5);
    hw_sel = 1'b0; idle(); rd(4); rd(5);

    // R9: status word
    cur = "R9";
    wr(6, 'hFFFF_FFFF); rd(6); wr(6, 'h12); rd(6);

    // R7: alert-test pulses, back to back, and read-back of zero
    cur = "R7";
    wr(0, 1); wr(0, 2); wr(0, 3); idle(); idle(); rd(0);

    // R10: unmapped word, writes give no response, back-to-back reads
    cur = "R10";
    rd(7); cyc(1, 0, 2, 0); cyc(1, 0, 6, 0); idle(); wr(7, 'hFF); idle();

    // R4: valid can only be set, bad encodings alert
    cur = "R4";
    wr(1, 9); wr(1, 9); rd(1);
    wr(1, 3); wr(1, 3); idle(); rd(1);
    wr(1, 6); wr(1, 6); rd(1); rd(5);

    // R6: lock ignores policy writes, no staging, no alert
    cur = "R6";
    wr(2, 'h44); wr(2, 'h44); wr(2, 'h45); idle(); rd(2);
    wr(3, 6); wr(3, 7); idle(); rd(3);
    wr(1, 9); wr(1, 9); rd(1);
    cur = "R9";
    wr(6, 'h10); rd(6);
    cur = "R7";
    wr(0, 2); idle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule